// File: doc/BRIEF.md
# Banked Supervisor Shadow Register File

This block is a small integer register file with eight general registers and four shadow registers. Its mode state is two bits: a supervisor flag and a shadow-enable flag. With shadow-enable clear, the four shadow indices are only other names for the upper four general registers. With shadow-enable set, the shadow registers have their own storage. In that mode, each change of the supervisor flag exchanges the upper four general registers with the shadow registers, so user and supervisor code each keep their own copy of those four registers.

Software drives the mode through a 32-bit status word write. Only two bit positions of that word are decoded. Reads on both the general and the shadow port are combinational from the stored state. Writes, mode changes and exchanges all take effect on one rising clock edge. A swap is decided from the shadow-enable value held before the write, not from the value being written.

Top module: `shadow_bank_rf`

## Requirements
- R1: After reset every general and shadow register reads zero, `sup_mode` is 1 and `shadow_en` is 0.
- R2: A general-port write to registers 1..7 is visible on `gr_rdata` in the cycle after the write edge.
- R3: General register 0 always reads zero, and writes to it are discarded.
- R4: While `shadow_en` is 0, shadow index n (0..3) reads and writes general register n+4.
- R5: While `shadow_en` is 1, shadow index n uses separate storage, and general registers 4..7 are not touched by shadow writes.
- R6: A status write whose bit 2 differs from `sup_mode` while `shadow_en` is 1 exchanges general register n+4 with shadow register n for every n, in one edge.
- R7: A status write whose bit 2 equals the current `sup_mode` performs no exchange.
- R8: The exchange decision uses the shadow-enable value held before the status write, not bit 11 of the word being written.
- R9: A status write loads `sup_mode` from bit 2 and `shadow_en` from bit 11, both visible after the write edge.
- R10: In a cycle with a status write, general-port and shadow-port writes are discarded.
- R11: While `shadow_en` is 0, if the general port writes a nonzero index in the same cycle as a shadow-port write, only the general-port write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| gr_raddr | input | 3 | General read index |
| gr_rdata | output | 32 | General read data |
| gr_we | input | 1 | General write enable |
| gr_waddr | input | 3 | General write index |
| gr_wdata | input | 32 | General write data |
| sr_raddr | input | 2 | Shadow read index |
| sr_rdata | output | 32 | Shadow read data |
| sr_we | input | 1 | Shadow write enable |
| sr_waddr | input | 2 | Shadow write index |
| sr_wdata | input | 32 | Shadow write data |
| stat_we | input | 1 | Status word write enable |
| stat_wdata | input | 32 | Status word (bit 2 supervisor, bit 11 shadow enable) |
| sup_mode | output | 1 | Current supervisor flag |
| shadow_en | output | 1 | Current shadow-enable flag |

## Verification
The bench goes after the exchange decision in both directions. A design that used the newly written enable bit would swap when enable is turned on together with a privilege change, and would fail to swap when enable is turned off together with one. Repeated writes of an unchanged supervisor bit are checked, because an edge-blind design would swap the banks back and forth. The bench also covers the aliasing of shadow indices onto registers 4..7, the zero register, and same-cycle collisions between status, general and shadow writes. A wrong priority in any of these would leave a register holding the losing port's data.

// File: rtl/sbrf_pkg.sv
// Package: shared mode-state type for the banked shadow register file.
// Assumes: nothing beyond IEEE 1800-2017 packed structs.
package sbrf_pkg;

    // Mode state held by the status unit.
    typedef struct packed {
        logic sup;  // supervisor flag
        logic esr;  // shadow-bank enable
    } sbrf_mode_t;

    // Reset value of the mode state: supervisor, shadows aliased.
    localparam sbrf_mode_t SBRF_MODE_RST = '{sup: 1'b1, esr: 1'b0};

endpackage

// File: rtl/sbrf_status.sv
// Module: sbrf_status
// Holds the supervisor and shadow-enable flags. It decodes them from a
// status word and raises swap_go when a write flips the supervisor flag
// while the currently held enable is set.
// Assumes: the bit positions given by the parameters lie inside STAT_W.
module sbrf_status
    import sbrf_pkg::*;
#(
    parameter int unsigned STAT_W  = 32,
    parameter int unsigned S_BIT   = 2,
    parameter int unsigned ESR_BIT = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stat_we,
    input  logic [STAT_W-1:0] stat_wdata,
    output sbrf_mode_t        mode,
    output logic              swap_go
);

    sbrf_mode_t mode_q;

    // Swap request: privilege flip judged against the old enable value.
    always_comb begin
        swap_go = stat_we && mode_q.esr && (stat_wdata[S_BIT] != mode_q.sup);
    end

    // Mode register: loads both flags from the status word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= SBRF_MODE_RST;
        end else if (stat_we) begin
            mode_q.sup <= stat_wdata[S_BIT];
            mode_q.esr <= stat_wdata[ESR_BIT];
        end
    end

    assign mode = mode_q;

endmodule

// File: rtl/sbrf_gpr.sv
// Module: sbrf_gpr
// General register storage. Entry 0 is a constant zero. The top NUM_SR
// entries load from the shadow bank when swap_go is high, and that takes
// precedence over the write port.
// Assumes: the top masks writes during a swap and never writes index 0.
module sbrf_gpr #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NUM_GR = 8,
    parameter int unsigned NUM_SR = 4,
    localparam int unsigned AW      = $clog2(NUM_GR),
    localparam int unsigned SR_BASE = NUM_GR - NUM_SR
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [AW-1:0]                  waddr,
    input  logic [DATA_W-1:0]              wdata,
    input  logic                           swap_go,
    input  logic [NUM_SR-1:0][DATA_W-1:0]  shadow_in,
    output logic [NUM_GR-1:0][DATA_W-1:0]  gr_q
);

    for (genvar g = 0; g < NUM_GR; g++) begin : g_reg
        if (g == 0) begin : g_zero
            // Zero register: constant, never stored.
            assign gr_q[g] = '0;
        end else if (g >= SR_BASE) begin : g_banked
            // Banked entry: swap source first, then the write port.
            always_ff @(posedge clk) begin
                if (!rst_n)                      gr_q[g] <= '0;
                else if (swap_go)                gr_q[g] <= shadow_in[g-SR_BASE];
                else if (we && waddr == AW'(g))  gr_q[g] <= wdata;
            end
        end else begin : g_plain
            // Plain entry: write port only.
            always_ff @(posedge clk) begin
                if (!rst_n)                      gr_q[g] <= '0;
                else if (we && waddr == AW'(g))  gr_q[g] <= wdata;
            end
        end
    end

endmodule

// File: rtl/sbrf_shadow.sv
// Module: sbrf_shadow
// Separate shadow storage. Each entry loads its paired general register
// when swap_go is high, and otherwise takes the write port.
// Assumes: the top only enables writes here while the shadow bank is on.
module sbrf_shadow #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NUM_SR = 4,
    localparam int unsigned AW = $clog2(NUM_SR)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [AW-1:0]                  waddr,
    input  logic [DATA_W-1:0]              wdata,
    input  logic                           swap_go,
    input  logic [NUM_SR-1:0][DATA_W-1:0]  gpr_in,
    output logic [NUM_SR-1:0][DATA_W-1:0]  sr_q
);

    for (genvar k = 0; k < NUM_SR; k++) begin : g_sreg
        // Shadow entry: swap source first, then the write port.
        always_ff @(posedge clk) begin
            if (!rst_n)                      sr_q[k] <= '0;
            else if (swap_go)                sr_q[k] <= gpr_in[k];
            else if (we && waddr == AW'(k))  sr_q[k] <= wdata;
        end
    end

endmodule

// File: rtl/shadow_bank_rf.sv
// Module: shadow_bank_rf (top)
// Register file with user/supervisor shadow banking. Shadow indices alias
// the upper general registers while banking is off, and are swapped with
// them on each privilege flip while banking is on.
// Assumes: one write per port per cycle; reads are combinational.
module shadow_bank_rf
    import sbrf_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned NUM_GR  = 8,
    parameter int unsigned NUM_SR  = 4,
    parameter int unsigned STAT_W  = 32,
    parameter int unsigned S_BIT   = 2,
    parameter int unsigned ESR_BIT = 11,
    localparam int unsigned GR_AW   = $clog2(NUM_GR),
    localparam int unsigned SR_AW   = $clog2(NUM_SR),
    localparam int unsigned SR_BASE = NUM_GR - NUM_SR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GR_AW-1:0]  gr_raddr,
    output logic [DATA_W-1:0] gr_rdata,
    input  logic              gr_we,
    input  logic [GR_AW-1:0]  gr_waddr,
    input  logic [DATA_W-1:0] gr_wdata,
    input  logic [SR_AW-1:0]  sr_raddr,
    output logic [DATA_W-1:0] sr_rdata,
    input  logic              sr_we,
    input  logic [SR_AW-1:0]  sr_waddr,
    input  logic [DATA_W-1:0] sr_wdata,
    input  logic              stat_we,
    input  logic [STAT_W-1:0] stat_wdata,
    output logic              sup_mode,
    output logic              shadow_en
);

    sbrf_mode_t                     mode;
    logic                           swap_go;
    logic [NUM_GR-1:0][DATA_W-1:0]  gr_vec;
    logic [NUM_SR-1:0][DATA_W-1:0]  sr_vec;
    logic                           gr_port_hit;
    logic                           alias_hit;
    logic                           g_we;
    logic [GR_AW-1:0]               g_waddr;
    logic [DATA_W-1:0]              g_wdata;
    logic                           s_we;

    sbrf_status #(
        .STAT_W (STAT_W),
        .S_BIT  (S_BIT),
        .ESR_BIT(ESR_BIT)
    ) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .stat_we   (stat_we),
        .stat_wdata(stat_wdata),
        .mode      (mode),
        .swap_go   (swap_go)
    );

    // Write steering: general port beats the alias path; status blocks both.
    always_comb begin
        gr_port_hit = gr_we && (gr_waddr != '0);
        alias_hit   = sr_we && !mode.esr;
        g_we        = !stat_we && (gr_port_hit || alias_hit);
        g_waddr     = gr_port_hit ? gr_waddr
                                  : GR_AW'(SR_BASE) + GR_AW'(sr_waddr);
        g_wdata     = gr_port_hit ? gr_wdata : sr_wdata;
        s_we        = !stat_we && sr_we && mode.esr;
    end

    sbrf_gpr #(
        .DATA_W(DATA_W),
        .NUM_GR(NUM_GR),
        .NUM_SR(NUM_SR)
    ) u_gpr (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (g_we),
        .waddr    (g_waddr),
        .wdata    (g_wdata),
        .swap_go  (swap_go),
        .shadow_in(sr_vec),
        .gr_q     (gr_vec)
    );

    sbrf_shadow #(
        .DATA_W(DATA_W),
        .NUM_SR(NUM_SR)
    ) u_shadow (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (s_we),
        .waddr  (sr_waddr),
        .wdata  (sr_wdata),
        .swap_go(swap_go),
        .gpr_in (gr_vec[NUM_GR-1:SR_BASE]),
        .sr_q   (sr_vec)
    );

    // Read muxes: shadow index follows the alias when banking is off.
    always_comb begin
        gr_rdata = gr_vec[gr_raddr];
        sr_rdata = mode.esr ? sr_vec[sr_raddr]
                            : gr_vec[GR_AW'(SR_BASE) + GR_AW'(sr_raddr)];
    end

    assign sup_mode  = mode.sup;
    assign shadow_en = mode.esr;

endmodule

// File: rtl/sbrf_checker.sv
// Module: sbrf_checker
// Temporal checks on the banked register file, attached by bind.
// Assumes: synchronous active-low reset; the register vectors come from the top.
module sbrf_checker #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned NUM_GR  = 8,
    parameter int unsigned NUM_SR  = 4,
    parameter int unsigned STAT_W  = 32,
    parameter int unsigned S_BIT   = 2,
    parameter int unsigned ESR_BIT = 11,
    localparam int unsigned GR_AW   = $clog2(NUM_GR),
    localparam int unsigned SR_AW   = $clog2(NUM_SR),
    localparam int unsigned SR_BASE = NUM_GR - NUM_SR
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          gr_we,
    input logic [GR_AW-1:0]              gr_waddr,
    input logic                          sr_we,
    input logic [SR_AW-1:0]              sr_waddr,
    input logic [DATA_W-1:0]             sr_wdata,
    input logic                          stat_we,
    input logic [STAT_W-1:0]             stat_wdata,
    input logic                          sup_mode,
    input logic                          shadow_en,
    input logic [NUM_GR-1:0][DATA_W-1:0] gr_vec,
    input logic [NUM_SR-1:0][DATA_W-1:0] sr_vec
);

    // The zero register never holds anything else.
    AST_GR0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        gr_vec[0] == '0);  // R3

    // The status flags follow the written word.
    AST_STATUS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        stat_we |=> (sup_mode == $past(stat_wdata[S_BIT]))
                 && (shadow_en == $past(stat_wdata[ESR_BIT])));  // R9

    // A write that keeps the supervisor flag leaves both banks alone.
    AST_NO_SWAP_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_we && stat_wdata[S_BIT] == sup_mode)
            |=> ($stable(sr_vec) && $stable(gr_vec)));  // R7

    // With banking off, a status flip does not move shadow storage.
    AST_NO_SWAP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_we && !shadow_en) |=> $stable(sr_vec));  // R8

    // With banking off, a lone shadow write lands in the aliased register.
    AST_ALIAS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_we && !shadow_en && !stat_we && !gr_we)
            |=> gr_vec[GR_AW'(SR_BASE) + GR_AW'($past(sr_waddr))]
                == $past(sr_wdata));  // R4

    // With banking on, a shadow write goes to separate storage only.
    AST_SHADOW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_we && shadow_en && !stat_we && !gr_we)
            |=> (sr_vec[$past(sr_waddr)] == $past(sr_wdata))
             && $stable(gr_vec));  // R5

    // A status write cycle suppresses both data write ports.
    AST_STAT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_we && !shadow_en && gr_waddr != '0)
            |=> $stable(gr_vec[SR_BASE-1:0]));  // R10

    for (genvar k = 0; k < NUM_SR; k++) begin : g_swap_chk
        // Every pair is exchanged on a flip with banking on.
        AST_SWAP_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_we && shadow_en && stat_wdata[S_BIT] != sup_mode)
                |=> (gr_vec[SR_BASE+k] == $past(sr_vec[k]))
                 && (sr_vec[k] == $past(gr_vec[SR_BASE+k])));  // R6
    end

endmodule

bind shadow_bank_rf sbrf_checker #(
    .DATA_W (DATA_W),
    .NUM_GR (NUM_GR),
    .NUM_SR (NUM_SR),
    .STAT_W (STAT_W),
    .S_BIT  (S_BIT),
    .ESR_BIT(ESR_BIT)
) u_sbrf_checker (.*);

// File: tb/shadow_bank_rf_tb_top.sv
// Directed bench for shadow_bank_rf: one task per scenario.
module shadow_bank_rf_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  gr_raddr = '0;
    logic [31:0] gr_rdata;
    logic        gr_we = 1'b0;
    logic [2:0]  gr_waddr = '0;
    logic [31:0] gr_wdata = '0;
    logic [1:0]  sr_raddr = '0;
    logic [31:0] sr_rdata;
    logic        sr_we = 1'b0;
    logic [1:0]  sr_waddr = '0;
    logic [31:0] sr_wdata = '0;
    logic        stat_we = 1'b0;
    logic [31:0] stat_wdata = '0;
    logic        sup_mode;
    logic        shadow_en;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Status words: bit 2 supervisor, bit 11 shadow enable.
    localparam logic [31:0] W_S1_E0 = 32'h0000_0004;
    localparam logic [31:0] W_S1_E1 = 32'h0000_0804;
    localparam logic [31:0] W_S0_E1 = 32'h0000_0800;

    always #2 clk = ~clk;  // 250 MHz

    shadow_bank_rf dut_i (
        .clk(clk), .rst_n(rst_n),
        .gr_raddr(gr_raddr), .gr_rdata(gr_rdata),
        .gr_we(gr_we), .gr_waddr(gr_waddr), .gr_wdata(gr_wdata),
        .sr_raddr(sr_raddr), .sr_rdata(sr_rdata),
        .sr_we(sr_we), .sr_waddr(sr_waddr), .sr_wdata(sr_wdata),
        .stat_we(stat_we), .stat_wdata(stat_wdata),
        .sup_mode(sup_mode), .shadow_en(shadow_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    task automatic wr_gr(input logic [2:0] a, input logic [31:0] d);
        gr_we = 1'b1; gr_waddr = a; gr_wdata = d;
        tick();
        gr_we = 1'b0;
    endtask

    task automatic wr_sr(input logic [1:0] a, input logic [31:0] d);
        sr_we = 1'b1; sr_waddr = a; sr_wdata = d;
        tick();
        sr_we = 1'b0;
    endtask

    task automatic wr_stat(input logic [31:0] w);
        stat_we = 1'b1; stat_wdata = w;
        tick();
        stat_we = 1'b0;
    endtask

    task automatic rd_gr(input logic [2:0] a, output logic [31:0] v);
        gr_raddr = a;
        #1;
        v = gr_rdata;
    endtask

    task automatic rd_sr(input logic [1:0] a, output logic [31:0] v);
        sr_raddr = a;
        #1;
        v = sr_rdata;
    endtask

    // R1: reset state of flags and every register.
    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        check("R1 sup after reset", {31'b0, sup_mode}, 32'd1);
        check("R1 esr after reset", {31'b0, shadow_en}, 32'd0);
        for (int i = 0; i < 8; i++) begin
            rd_gr(3'(i), v);
            check("R1 gr zero", v, 32'h0);
        end
        wr_stat(W_S1_E1);
        for (int i = 0; i < 4; i++) begin
            rd_sr(2'(i), v);
            check("R1 sr zero", v, 32'h0);
        end
    endtask

    // R2, R3: general writes and the zero register.
    task automatic t_gr_basic();
        logic [31:0] v;
        do_reset();
        for (int i = 1; i < 8; i++) wr_gr(3'(i), 32'h1000 + i);
        wr_gr(3'd0, 32'hFFFF_FFFF);
        rd_gr(3'd0, v);
        check("R3 gr0 reads zero", v, 32'h0);
        for (int i = 1; i < 8; i++) begin
            rd_gr(3'(i), v);
            check("R2 gr readback", v, 32'h1000 + i);
        end
    endtask

    // R4: shadow indices alias registers 4..7 while banking is off.
    task automatic t_alias();
        logic [31:0] v;
        do_reset();
        wr_sr(2'd2, 32'h77);
        rd_gr(3'd6, v);
        check("R4 sr2 write lands in gr6", v, 32'h77);
        wr_gr(3'd5, 32'h88);
        rd_sr(2'd1, v);
        check("R4 sr1 reads gr5", v, 32'h88);
    endtask

    // R5, R9: enabling banking gives separate shadow storage.
    task automatic t_separate();
        logic [31:0] v;
        do_reset();
        wr_stat(W_S1_E1);
        check("R9 esr loaded from bit 11", {31'b0, shadow_en}, 32'd1);
        check("R9 sup loaded from bit 2", {31'b0, sup_mode}, 32'd1);
        wr_gr(3'd4, 32'h44);
        wr_sr(2'd0, 32'h99);
        rd_gr(3'd4, v);
        check("R5 gr4 kept", v, 32'h44);
        rd_sr(2'd0, v);
        check("R5 sr0 separate", v, 32'h99);
    endtask

    // R6, R7: exchange on flips, none on repeats.
    task automatic t_swap();
        logic [31:0] v;
        do_reset();
        wr_stat(W_S1_E1);
        for (int i = 0; i < 4; i++) wr_gr(3'(4 + i), 32'hA0 + i);
        for (int i = 0; i < 4; i++) wr_sr(2'(i), 32'hB0 + i);
        wr_stat(W_S0_E1);
        check("R9 sup cleared", {31'b0, sup_mode}, 32'd0);
        for (int i = 0; i < 4; i++) begin
            rd_gr(3'(4 + i), v);
            check("R6 gr gets shadow", v, 32'hB0 + i);
            rd_sr(2'(i), v);
            check("R6 shadow gets gr", v, 32'hA0 + i);
        end
        wr_stat(W_S0_E1);
        for (int i = 0; i < 4; i++) begin
            rd_gr(3'(4 + i), v);
            check("R7 no swap on same S", v, 32'hB0 + i);
        end
        wr_stat(W_S1_E1);
        for (int i = 0; i < 4; i++) begin
            rd_gr(3'(4 + i), v);
            check("R6 swap back", v, 32'hA0 + i);
        end
    endtask

    // R8: the enable held before the write decides the exchange.
    task automatic t_old_esr();
        logic [31:0] v;
        do_reset();
        for (int i = 0; i < 4; i++) wr_gr(3'(4 + i), 32'hC0 + i);
        wr_stat(W_S0_E1);
        for (int i = 0; i < 4; i++) begin
            rd_gr(3'(4 + i), v);
            check("R8 no swap when old esr 0", v, 32'hC0 + i);
            rd_sr(2'(i), v);
            check("R8 shadow untouched", v, 32'h0);
        end
        for (int i = 0; i < 4; i++) wr_sr(2'(i), 32'hD0 + i);
        wr_stat(W_S1_E0);
        check("R8 esr now off", {31'b0, shadow_en}, 32'd0);
        for (int i = 0; i < 4; i++) begin
            rd_gr(3'(4 + i), v);
            check("R8 swap when old esr 1", v, 32'hD0 + i);
        end
        wr_stat(W_S1_E1);
        for (int i = 0; i < 4; i++) begin
            rd_sr(2'(i), v);
            check("R8 shadow holds old gr", v, 32'hC0 + i);
        end
    endtask

    // R10: data writes in a status write cycle are dropped.
    task automatic t_stat_blocks();
        logic [31:0] v;
        do_reset();
        stat_we = 1'b1; stat_wdata = W_S1_E0;
        gr_we = 1'b1; gr_waddr = 3'd1; gr_wdata = 32'h55;
        sr_we = 1'b1; sr_waddr = 2'd0; sr_wdata = 32'h66;
        tick();
        stat_we = 1'b0; gr_we = 1'b0; sr_we = 1'b0;
        rd_gr(3'd1, v);
        check("R10 gr write dropped", v, 32'h0);
        rd_gr(3'd4, v);
        check("R10 alias write dropped", v, 32'h0);
    endtask

    // R11: the general port wins over the alias path.
    task automatic t_port_priority();
        logic [31:0] v;
        do_reset();
        gr_we = 1'b1; gr_waddr = 3'd1; gr_wdata = 32'h11;
        sr_we = 1'b1; sr_waddr = 2'd2; sr_wdata = 32'h22;
        tick();
        gr_we = 1'b0; sr_we = 1'b0;
        rd_gr(3'd1, v);
        check("R11 gr port applied", v, 32'h11);
        rd_gr(3'd6, v);
        check("R11 alias write dropped", v, 32'h0);
    endtask

    initial begin
        t_reset();
        t_gr_basic();
        t_alias();
        t_separate();
        t_swap();
        t_old_esr();
        t_stat_blocks();
        t_port_priority();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule